// File: doc/BRIEF.md
# DDR Bank Command Timing Sequencer

The sequencer sits between a local request port and the command pins of a four-bank DDR SDRAM. A requester presents one operation at a time (open a row, read, write, close one bank, close all banks, or load the mode register) together with a bank number and an address word. The block turns the accepted request into the chip-select, RAS, CAS and WE levels plus bank and address fields for exactly one clock. It also keeps a record of which banks hold an open row and which row that is.

Every spacing rule is held in small down-counters, one set per bank and one set for the whole device. All counters are sized in whole clocks; each value is the time in nanoseconds divided by the clock period and rounded up. A request that would break any rule is held with `req_ready` low until the rule is met. It is never discarded. Auto-precharge (address bit 10 on a read or write) closes the bank in the record at once. The next open of that bank is then pushed out by the burst length, the write recovery when the burst is a write, the remaining minimum active time and the precharge time.

A two-state controller governs acceptance. In `ST_ACCEPT` requests are granted whenever the counters allow. A mode register load moves it to `ST_MRD_WAIT` (transition `mrs_taken`), where nothing is granted. It returns to `ST_ACCEPT` (transition `mrd_done`) once the mode-load gap has elapsed. When the mode-load gap is a single clock, the `mrs_taken` transition is skipped.

Top module: `ddr_cmd_sequencer`

## Requirements
- R1: After reset the pins show a deselect (chip select high, RAS/CAS/WE = 111, bank and address 0) and every bank is closed.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. The command appears on the pins for the following cycle only, with chip select low and RAS/CAS/WE = 011 open, 101 read, 100 write, 010 precharge, 000 mode load. Request codes are 0 open, 1 read, 2 write, 3 precharge, 4 precharge-all, 5 mode load; codes 6 and 7 are never accepted. A read or write drives the column in A9..A0 and the auto-precharge flag in A10, with A11 and A12 zero. A precharge drives only A10, which is high for a close-all.
- R3: A read or write to a bank is accepted only while that bank is open, and no earlier than T_RCD clocks after its open.
- R4: An open is accepted only for a closed bank, no earlier than T_RC clocks after the previous open of the same bank, and no earlier than T_RRD clocks after an open of any bank.
- R5: An explicit close of an open bank waits T_RAS clocks after its open. A reopen of the bank waits T_RP clocks after the close.
- R6: An explicit close also waits BL/2 clocks after a read and BL/2 + T_WR clocks after a write to that bank. `bl_sel` selects BL: 0 gives 2, 1 gives 4, and 2 or 3 gives 8.
- R7: A read or write with A10 high closes the bank at acceptance. The next open of that bank waits max(recovery, remaining T_RAS) + T_RP clocks, where recovery is BL/2 for a read and BL/2 + T_WR for a write.
- R8: A close-all, or a precharge with A10 high whatever the bank bits, waits until every open bank may be closed, then closes all banks.
- R9: A read waits BL/2 + 1 + T_WTR clocks after any write.
- R10: A mode load is accepted only when all banks are closed and their precharge time has elapsed. No request is accepted for T_MRD clocks after it.
- R11: While `cmd_hold` is high no request is accepted, and all timers keep counting.
- R12: `row_hit` is high exactly when the bank named by `req_bank` is open on the row equal to `req_addr`.
- R13: A precharge of a closed bank is accepted without waiting and leaves that bank's timers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Request code (R2) |
| req_bank | input | 2 | Target bank |
| req_addr | input | 13 | Row, or column plus A10 flag |
| bl_sel | input | 2 | Burst length select (R6) |
| cmd_hold | input | 1 | Blocks acceptance while high |
| req_ready | output | 1 | Request may be taken this cycle |
| row_hit | output | 1 | Addressed bank open on `req_addr` |
| bank_open | output | 4 | Per-bank open flags |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 2 | Bank field |
| ddr_addr | output | 13 | Address field |

## Verification
The subtle coincidence is an auto-precharge whose burst recovery and remaining minimum active time run out together or overlap. This makes the reopen of a bank bounded by two rules in the same cycle. A release of `cmd_hold` can also coincide with the expiry of a spacing counter. Both cases are provoked by issuing requests back to back, each held until it is granted. The bench then compares the cycle of every grant, and every pin value, against a behavioural model built on absolute earliest-allowed times. It also checks the exact grant cycle against values derived by hand from the rules.

// File: rtl/ddrseq_pkg.sv
package ddrseq_pkg;

    typedef enum logic [2:0] {
        OP_ACT  = 3'd0,
        OP_RD   = 3'd1,
        OP_WR   = 3'd2,
        OP_PRE  = 3'd3,
        OP_PREA = 3'd4,
        OP_MRS  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic {
        ST_ACCEPT,
        ST_MRD_WAIT
    } seq_state_e;

    localparam logic [2:0] CMD_ACT = 3'b011;
    localparam logic [2:0] CMD_RD  = 3'b101;
    localparam logic [2:0] CMD_WR  = 3'b100;
    localparam logic [2:0] CMD_PRE = 3'b010;
    localparam logic [2:0] CMD_MRS = 3'b000;
    localparam logic [2:0] CMD_NOP = 3'b111;

    function automatic logic [2:0] cmd_code(input op_e op);
        case (op)
            OP_ACT:          return CMD_ACT;
            OP_RD:           return CMD_RD;
            OP_WR:           return CMD_WR;
            OP_PRE, OP_PREA: return CMD_PRE;
            OP_MRS:          return CMD_MRS;
            default:         return CMD_NOP;
        endcase
    endfunction

endpackage

// File: rtl/ddrseq_bank.sv
module ddrseq_bank
    import ddrseq_pkg::*;
#(
    parameter int CW    = 8,
    parameter int ROW_W = 13,
    parameter int T_RCD = 3,
    parameter int T_RC  = 10,
    parameter int T_RAS = 7,
    parameter int T_RP  = 3,
    parameter int T_WR  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             rw_go,
    input  logic             rw_wr,
    input  logic             rw_ap,
    input  logic             pre_go,
    input  logic [ROW_W-1:0] row_in,
    input  logic [CW-1:0]    bl_half,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             act_ok,
    output logic             rw_ok,
    output logic             pre_ok,
    output logic             idle_ok
);

    localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] L_RC  = CW'(T_RC - 1);
    localparam logic [CW-1:0] L_RAS = CW'(T_RAS - 1);
    localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_WR  = CW'(T_WR);

    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [CW-1:0]    rcd_q, rc_q, ras_q, rp_q, rec_q;
    logic [CW-1:0]    recov, ap_wait, rec_dec, rec_next;

    function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    always_comb begin
        recov    = bl_half + (rw_wr ? L_WR : '0);
        ap_wait  = ((recov > ras_q) ? recov : ras_q) + L_RP;
        rec_dec  = dec(rec_q);
        rec_next = (rec_dec > recov - 1'b1) ? rec_dec : recov - 1'b1;
    end

    assign open_o  = open_q;
    assign row_o   = row_q;
    assign act_ok  = !open_q && rc_q == '0 && rp_q == '0;
    assign rw_ok   = open_q && rcd_q == '0;
    assign pre_ok  = !open_q || (ras_q == '0 && rec_q == '0);
    assign idle_ok = !open_q && rp_q == '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
            rcd_q  <= '0;
            rc_q   <= '0;
            ras_q  <= '0;
            rp_q   <= '0;
            rec_q  <= '0;
        end else begin
            rcd_q <= dec(rcd_q);
            rc_q  <= dec(rc_q);
            ras_q <= dec(ras_q);
            rp_q  <= dec(rp_q);
            rec_q <= rec_dec;
            if (act_go) begin
                open_q <= 1'b1;
                row_q  <= row_in;
                rcd_q  <= L_RCD;
                rc_q   <= L_RC;
                ras_q  <= L_RAS;
            end
            if (rw_go) begin
                if (rw_ap) begin
                    open_q <= 1'b0;
                    rp_q   <= ap_wait;
                end else begin
                    rec_q <= rec_next;
                end
            end
            if (pre_go && open_q) begin
                open_q <= 1'b0;
                rp_q   <= L_RP;
            end
        end
    end

    assert_rw_needs_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rw_go |-> (open_q && rcd_q == '0));

    assert_act_needs_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> (!open_q && rc_q == '0 && rp_q == '0));

    assert_close_after_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_go && open_q) |-> (ras_q == '0 && rec_q == '0));

    assert_ap_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_go && rw_ap) |=> !open_q);

endmodule

// File: rtl/ddrseq_gate.sv
module ddrseq_gate #(
    parameter int CW    = 8,
    parameter int T_RRD = 2,
    parameter int T_WTR = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_go,
    input  logic          rd_go,
    input  logic          wr_go,
    input  logic [CW-1:0] bl_half,
    output logic          act_ok,
    output logic          rd_ok
);

    localparam logic [CW-1:0] L_RRD = CW'(T_RRD - 1);
    localparam logic [CW-1:0] L_WTR = CW'(T_WTR);

    logic [CW-1:0] rrd_q, wtr_q;

    assign act_ok = (rrd_q == '0);
    assign rd_ok  = (wtr_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_q <= '0;
            wtr_q <= '0;
        end else begin
            rrd_q <= act_go ? L_RRD : ((rrd_q == '0) ? rrd_q : rrd_q - 1'b1);
            wtr_q <= wr_go ? (bl_half + L_WTR) : ((wtr_q == '0) ? wtr_q : wtr_q - 1'b1);
        end
    end

    assert_rrd_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> rrd_q == '0);

    assert_wtr_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |-> wtr_q == '0);

endmodule

// File: rtl/ddr_cmd_sequencer.sv
module ddr_cmd_sequencer
    import ddrseq_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    parameter int BA_W  = 2,
    parameter int CW    = 8,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RRD = 2,
    parameter int T_RC  = 10,
    parameter int T_RAS = 7,
    parameter int T_WR  = 3,
    parameter int T_WTR = 1,
    parameter int T_MRD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_addr,
    input  logic [1:0]       bl_sel,
    input  logic             cmd_hold,
    output logic             req_ready,
    output logic             row_hit,
    output logic [(1<<BA_W)-1:0] bank_open,
    output logic             ddr_cs_n,
    output logic             ddr_ras_n,
    output logic             ddr_cas_n,
    output logic             ddr_we_n,
    output logic [BA_W-1:0]  ddr_ba,
    output logic [ROW_W-1:0] ddr_addr
);

    localparam int NBANK  = 1 << BA_W;
    localparam int AP_BIT = COL_W;
    localparam logic [CW-1:0] L_MRD = CW'(T_MRD - 1);

    op_e           op;
    seq_state_e    state_q, state_d;
    logic [CW-1:0] mrd_q;
    logic [CW-1:0] bl_half;
    logic          ap_flag, pre_all, grant_ok, fire;
    logic          g_act_ok, g_rd_ok;
    logic [NBANK-1:0] act_go, rw_go, pre_go, hit_bank;
    logic [NBANK-1:0] act_ok_v, rw_ok_v, pre_ok_v, idle_ok_v;
    logic [ROW_W-1:0] row_v [NBANK];
    logic [ROW_W-1:0] addr_d;

    assign op      = op_e'(req_op);
    assign ap_flag = req_addr[AP_BIT];
    assign pre_all = (op == OP_PREA) || (op == OP_PRE && ap_flag);

    always_comb begin
        unique case (bl_sel)
            2'd0:    bl_half = CW'(1);
            2'd1:    bl_half = CW'(2);
            default: bl_half = CW'(4);
        endcase
    end

    always_comb begin
        unique case (op)
            OP_ACT:  grant_ok = act_ok_v[req_bank] && g_act_ok;
            OP_RD:   grant_ok = rw_ok_v[req_bank] && g_rd_ok;
            OP_WR:   grant_ok = rw_ok_v[req_bank];
            OP_PRE:  grant_ok = pre_all ? (&pre_ok_v) : pre_ok_v[req_bank];
            OP_PREA: grant_ok = &pre_ok_v;
            OP_MRS:  grant_ok = &idle_ok_v;
            default: grant_ok = 1'b0;
        endcase
    end

    assign req_ready = (state_q == ST_ACCEPT) && !cmd_hold && grant_ok;
    assign fire      = req_valid && req_ready;
    assign row_hit   = bank_open[req_bank] && (row_v[req_bank] == req_addr);

    generate
        for (genvar i = 0; i < NBANK; i++) begin : g_bank
            assign hit_bank[i] = (req_bank == BA_W'(i));
            assign act_go[i]   = fire && op == OP_ACT && hit_bank[i];
            assign rw_go[i]    = fire && (op == OP_RD || op == OP_WR) && hit_bank[i];
            assign pre_go[i]   = fire && (pre_all || (op == OP_PRE && hit_bank[i]));

            ddrseq_bank #(
                .CW(CW), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RC(T_RC),
                .T_RAS(T_RAS), .T_RP(T_RP), .T_WR(T_WR)
            ) u_bank (
                .clk(clk), .rst_n(rst_n),
                .act_go(act_go[i]), .rw_go(rw_go[i]), .rw_wr(op == OP_WR),
                .rw_ap(ap_flag), .pre_go(pre_go[i]), .row_in(req_addr),
                .bl_half(bl_half), .open_o(bank_open[i]), .row_o(row_v[i]),
                .act_ok(act_ok_v[i]), .rw_ok(rw_ok_v[i]),
                .pre_ok(pre_ok_v[i]), .idle_ok(idle_ok_v[i])
            );
        end
    endgenerate

    ddrseq_gate #(.CW(CW), .T_RRD(T_RRD), .T_WTR(T_WTR)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .act_go(fire && op == OP_ACT), .rd_go(fire && op == OP_RD),
        .wr_go(fire && op == OP_WR), .bl_half(bl_half),
        .act_ok(g_act_ok), .rd_ok(g_rd_ok)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCEPT:   if (fire && op == OP_MRS && T_MRD > 1) state_d = ST_MRD_WAIT;
            ST_MRD_WAIT: if (mrd_q <= CW'(1)) state_d = ST_ACCEPT;
            default:     state_d = ST_ACCEPT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACCEPT;
            mrd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (fire && op == OP_MRS) mrd_q <= L_MRD;
            else if (mrd_q != '0)     mrd_q <= mrd_q - 1'b1;
        end
    end

    always_comb begin
        addr_d = '0;
        unique case (op)
            OP_ACT, OP_MRS: addr_d = req_addr;
            OP_RD, OP_WR: begin
                addr_d[COL_W-1:0] = req_addr[COL_W-1:0];
                addr_d[AP_BIT]    = ap_flag;
            end
            OP_PRE, OP_PREA: addr_d[AP_BIT] = pre_all;
            default: addr_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !fire) begin
            ddr_cs_n <= 1'b1;
            {ddr_ras_n, ddr_cas_n, ddr_we_n} <= CMD_NOP;
            ddr_ba   <= '0;
            ddr_addr <= '0;
        end else begin
            ddr_cs_n <= 1'b0;
            {ddr_ras_n, ddr_cas_n, ddr_we_n} <= cmd_code(op);
            ddr_ba   <= req_bank;
            ddr_addr <= addr_d;
        end
    end

    assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> ddr_cs_n);

    assert_hold_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_hold |-> !req_ready);

    assert_mrs_all_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == OP_MRS) |-> bank_open == '0);

    assert_mrs_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op == OP_MRS && T_MRD > 1) |=> !req_ready);

endmodule

// File: tb/tb_ddr_cmd_sequencer.sv
module tb_ddr_cmd_sequencer;

    localparam int T_RCD = 3, T_RP = 3, T_RRD = 2, T_RC = 10;
    localparam int T_RAS = 7, T_WR = 3, T_WTR = 1, T_MRD = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, cmd_hold, req_ready, row_hit;
    logic [2:0] req_op;
    logic [1:0] req_bank, bl_sel;
    logic [12:0] req_addr;
    logic [3:0] bank_open;
    logic ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
    logic [1:0] ddr_ba;
    logic [12:0] ddr_addr;

    always #4 clk = ~clk;

    ddr_cmd_sequencer #(
        .T_RCD(T_RCD), .T_RP(T_RP), .T_RRD(T_RRD), .T_RC(T_RC),
        .T_RAS(T_RAS), .T_WR(T_WR), .T_WTR(T_WTR), .T_MRD(T_MRD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_addr(req_addr), .bl_sel(bl_sel),
        .cmd_hold(cmd_hold), .req_ready(req_ready), .row_hit(row_hit),
        .bank_open(bank_open), .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n),
        .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n), .ddr_ba(ddr_ba),
        .ddr_addr(ddr_addr)
    );

    int n_checks = 0, n_fail = 0, now = 0;
    bit m_open [4];
    int m_row [4], rcd_t [4], rc_t [4], ras_t [4], pre_t [4], rec_t [4];
    int rrd_t = 0, wtr_t = 0, mrd_t = 0;
    logic e_cs_n;
    logic [2:0] e_cmd;
    logic [1:0] e_ba;
    logic [12:0] e_addr;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int bl2();
        return (bl_sel == 2'd0) ? 1 : (bl_sel == 2'd1) ? 2 : 4;
    endfunction

    function automatic bit close_ok(input int b);
        return !m_open[b] || (now >= ras_t[b] && now >= rec_t[b]);
    endfunction

    function automatic bit all_close_ok();
        for (int b = 0; b < 4; b++) if (!close_ok(b)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit m_ready();
        int b = int'(req_bank);
        if (cmd_hold || now < mrd_t) return 1'b0;
        case (req_op)
            3'd0: return !m_open[b] && now >= rc_t[b] && now >= pre_t[b] && now >= rrd_t;
            3'd1: return m_open[b] && now >= rcd_t[b] && now >= wtr_t;
            3'd2: return m_open[b] && now >= rcd_t[b];
            3'd3: return req_addr[10] ? all_close_ok() : close_ok(b);
            3'd4: return all_close_ok();
            3'd5: begin
                for (int k = 0; k < 4; k++) if (m_open[k] || now < pre_t[k]) return 1'b0;
                return 1'b1;
            end
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of();
        if (cmd_hold) return "R11 ready";
        case (req_op)
            3'd0: return "R4 ready";
            3'd1: return "R9 ready";
            3'd2: return "R3 ready";
            3'd3: return "R5 ready";
            3'd4: return "R8 ready";
            3'd5: return "R10 ready";
            default: return "R2 ready";
        endcase
    endfunction

    task automatic m_update();
        int b = int'(req_bank);
        int rv;
        e_cs_n = 1'b0;
        e_ba = req_bank;
        e_addr = 13'h0;
        case (req_op)
            3'd0: begin
                e_cmd = 3'b011; e_addr = req_addr;
                m_open[b] = 1; m_row[b] = int'(req_addr);
                rcd_t[b] = now + T_RCD; rc_t[b] = now + T_RC;
                ras_t[b] = now + T_RAS; rrd_t = now + T_RRD;
            end
            3'd1, 3'd2: begin
                e_cmd = (req_op == 3'd1) ? 3'b101 : 3'b100;
                e_addr = {2'b00, req_addr[10:0]};
                rv = bl2() + ((req_op == 3'd2) ? T_WR : 0);
                if (req_op == 3'd2) wtr_t = now + bl2() + 1 + T_WTR;
                if (req_addr[10]) begin
                    m_open[b] = 0;
                    pre_t[b] = mx(now + rv, ras_t[b]) + T_RP;
                end else rec_t[b] = mx(rec_t[b], now + rv);
            end
            3'd3, 3'd4: begin
                e_cmd = 3'b010;
                if (req_op == 3'd4 || req_addr[10]) begin
                    e_addr = 13'h400;
                    for (int k = 0; k < 4; k++)
                        if (m_open[k]) begin m_open[k] = 0; pre_t[k] = now + T_RP; end
                end else if (m_open[b]) begin
                    m_open[b] = 0; pre_t[b] = now + T_RP;
                end
            end
            default: begin
                e_cmd = 3'b000; e_addr = req_addr; mrd_t = now + T_MRD;
            end
        endcase
    endtask

    task automatic step(output bit acc);
        bit er;
        logic [3:0] ov;
        #1;
        for (int k = 0; k < 4; k++) ov[k] = m_open[k];
        chk("R2 cs_n", ddr_cs_n, e_cs_n);
        chk("R2 cmd", {ddr_ras_n, ddr_cas_n, ddr_we_n}, e_cmd);
        chk("R2 ba", ddr_ba, e_ba);
        chk("R2 addr", ddr_addr, e_addr);
        chk("R8 bank_open", bank_open, ov);
        chk("R12 row_hit", row_hit, m_open[req_bank] && m_row[req_bank] == int'(req_addr));
        er = m_ready();
        chk(tag_of(), req_ready, er);
        @(posedge clk);
        acc = req_valid && er;
        if (acc) m_update();
        else begin e_cs_n = 1'b1; e_cmd = 3'b111; e_ba = 2'd0; e_addr = 13'h0; end
        now++;
        @(negedge clk);
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] b,
                         input logic [12:0] a, output int t);
        bit acc;
        req_valid = 1'b1; req_op = op; req_bank = b; req_addr = a; t = -1;
        for (int k = 0; k < 200; k++) begin
            step(acc);
            if (acc) begin t = now - 1; break; end
        end
        req_valid = 1'b0;
        if (t < 0) chk("R2 request never granted", 0, 1);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int t_mrs, ta0, ta1, tr0, tw1, tr1, tp1, ta1b, trap, ta0b, twap, ta0c;
        int tpa, tpc, ta3, tstart, ta2, tprea, tmrs2;
        bit acc;
        for (int k = 0; k < 4; k++) begin
            m_open[k] = 0; m_row[k] = 0; rcd_t[k] = 0; rc_t[k] = 0;
            ras_t[k] = 0; pre_t[k] = 0; rec_t[k] = 0;
        end
        e_cs_n = 1'b1; e_cmd = 3'b111; e_ba = 2'd0; e_addr = 13'h0;
        rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd0; req_bank = 2'd0;
        req_addr = 13'h0; bl_sel = 2'd1; cmd_hold = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset cs_n", ddr_cs_n, 1'b1);
        chk("R1 reset cmd", {ddr_ras_n, ddr_cas_n, ddr_we_n}, 3'b111);
        chk("R1 reset bank_open", bank_open, 4'h0);
        @(negedge clk);

        issue(3'd5, 2'd0, 13'h031, t_mrs);
        issue(3'd0, 2'd0, 13'd5, ta0);
        chk("R10 open after mode load gap", ta0 - t_mrs, T_MRD);
        issue(3'd0, 2'd1, 13'd9, ta1);
        chk("R4 open to other bank gap", ta1 - ta0, T_RRD);

        req_op = 3'd0; req_bank = 2'd0; req_addr = 13'd5; #1;
        chk("R12 row_hit on open row", row_hit, 1'b1);
        req_addr = 13'd6; #1;
        chk("R12 row_hit on other row", row_hit, 1'b0);

        issue(3'd1, 2'd0, 13'd3, tr0);
        chk("R3 read after open", tr0 - ta0, T_RCD);
        issue(3'd2, 2'd1, 13'd7, tw1);
        chk("R3 write after open", tw1 - ta1, T_RCD);
        issue(3'd1, 2'd1, 13'd8, tr1);
        chk("R9 read after write", tr1 - tw1, 2 + 1 + T_WTR);
        issue(3'd3, 2'd1, 13'd0, tp1);
        chk("R6 close after read/write", tp1,
            mx(mx(ta1 + T_RAS, tw1 + 2 + T_WR), tr1 + 2));
        issue(3'd0, 2'd1, 13'd9, ta1b);
        chk("R5 reopen after close", ta1b - tp1, T_RP);

        issue(3'd1, 2'd0, 13'h404, trap);
        issue(3'd0, 2'd0, 13'd11, ta0b);
        chk("R7 reopen after read auto-precharge", ta0b,
            mx(mx(mx(trap + 2, ta0 + T_RAS) + T_RP, ta0 + T_RC), mx(ta1b + T_RRD, trap + 1)));

        bl_sel = 2'd2;
        issue(3'd2, 2'd0, 13'h405, twap);
        chk("R3 write after reopen", twap - ta0b, T_RCD);
        issue(3'd0, 2'd0, 13'd12, ta0c);
        chk("R7 reopen after write auto-precharge", ta0c - twap, 4 + T_WR + T_RP);

        issue(3'd3, 2'd2, 13'h400, tpa);
        chk("R8 close-all waits on active time", tpa - ta0c, T_RAS);
        issue(3'd3, 2'd3, 13'h000, tpc);
        chk("R13 close of closed bank immediate", tpc - tpa, 1);
        issue(3'd0, 2'd3, 13'd20, ta3);
        chk("R13 open after close of closed bank", ta3 - tpc, 1);

        cmd_hold = 1'b1; req_valid = 1'b1; req_op = 3'd0; req_bank = 2'd2; req_addr = 13'd21;
        for (int k = 0; k < 5; k++) begin
            step(acc);
            chk("R11 held request not taken", acc, 1'b0);
        end
        cmd_hold = 1'b0;
        tstart = now;
        issue(3'd0, 2'd2, 13'd21, ta2);
        chk("R11 taken on release", ta2, tstart);

        issue(3'd4, 2'd0, 13'h000, tprea);
        chk("R8 close-all after active time", tprea, mx(ta2 + T_RAS, tstart + 1 - 1));
        issue(3'd5, 2'd0, 13'h022, tmrs2);
        chk("R10 mode load after close", tmrs2 - tprea, T_RP);

        bl_sel = 2'd0;
        issue(3'd0, 2'd0, 13'd30, ta0);
        issue(3'd1, 2'd0, 13'h001, tr0);
        issue(3'd3, 2'd0, 13'h000, tp1);
        chk("R6 close after short burst read", tp1, mx(ta0 + T_RAS, tr0 + 1));

        for (int k = 0; k < 4; k++) step(acc);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule